// File: doc/BRIEF.md
# Single-Port RAM with Configurable Read Output Pipeline

This block is a single-port synchronous RAM whose read data passes through a chain of register stages that can be configured. The raw array read is captured in a latch register on each enabled clock. After it come an optional primitive output register, zero to two optional pipeline registers and an optional core output register, in that order. The designer chooses the stages to trade read latency against timing margin. The read latency in clocks is one plus the number of stages present.

The output reset and the output clock enable act only on the stage that ends the chain. Earlier stages ignore both signals and move forward on every clock. The last stage therefore acts as a gate: a reset loads a parameterised value whatever the enable is doing, and a low clock enable freezes the value shown. Upstream data keeps flowing while the gate is closed. When no register stage is configured, the latch is itself the last stage and takes both controls.

Top module: `rdp_ram_top`

## Requirements
- R1: A write stores `wdata` at `addr` only at a clock edge where both `en` and `we` are high. With `en` low the array is unchanged, even when `we` is high.
- R2: A write with `en` high presents its write data on the latch in the same edge (write-first), so that data reaches `rdata` with the normal read latency.
- R3: Data read at an edge with `en` high appears on `rdata` after 1 + P + S + C clock edges. P is 1 when the primitive register is used, S is the number of pipeline registers (0 to 2) and C is 1 when the core register is used. The output does not change before that edge.
- R4: With `en` low, the latch keeps its last value, so `rdata` settles to that value and stays there.
- R5: When `out_rst` is high at an edge, the last stage loads `RST_VAL`, whatever the level of `en`.
- R6: When `out_rst` and `out_ce` are both high, the reset wins and the last stage loads `RST_VAL`.
- R7: With `out_rst` low and `out_ce` low, the last stage holds its value.
- R8: Stages before the last ignore `out_rst` and `out_ce` and load the previous stage's value on every edge.
- R9: With no register stage configured, `out_rst` and `out_ce` act on the latch. The latch resets on `out_rst` and otherwise updates only when both `en` and `out_ce` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| en | input | 1 | Enables the array read and the array write |
| we | input | 1 | Write enable, qualified by `en` |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | DATA_W | Write data |
| out_rst | input | 1 | Synchronous active-high reset of the last stage |
| out_ce | input | 1 | Clock enable of the last stage |
| rdata | output | DATA_W | Read data from the last stage |

## Verification
An intermediate stage that wrongly obeyed the reset or the clock enable would show at `rdata` one edge after the last stage reopens. At that point the port would carry the reset value or a stale word instead of the word upstream. A stage that is missing or doubled moves the first change of `rdata` one edge early or late, so the bench samples on the edge before the expected change and on the edge itself. A latch that updates with `en` low, or a write that lands with `en` low, corrupts the next value read back from that address.

// File: rtl/rdp_pkg.sv
`timescale 1ns/1ps
package rdp_pkg;
    function automatic int stage_count(input bit prim, input int pipe, input bit core);
        return int'(prim) + pipe + int'(core);
    endfunction

    function automatic int read_latency(input bit prim, input int pipe, input bit core);
        return 1 + stage_count(prim, pipe, core);
    endfunction
endpackage

// File: rtl/rdp_array.sv
`timescale 1ns/1ps
module rdp_array #(
    parameter int              DATA_W  = 16,
    parameter int              DEPTH   = 16,
    parameter bit              IS_LAST = 1'b0,
    parameter logic [DATA_W-1:0] RST_VAL = '1,
    localparam int             ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rst,
    input  logic              ce,
    output logic [DATA_W-1:0] latch
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_word;
    logic              ld_latch;
    logic              rst_latch;
    logic              past_ok = 1'b0;

    always_ff @(posedge clk) past_ok <= 1'b1;

    // array write, gated by enable
    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= wdata;
    end

    // write-first selection
    always_comb rd_word = we ? wdata : mem[addr];

    // output controls touch the latch only when it is the last stage
    always_comb begin
        rst_latch = IS_LAST && rst;
        ld_latch  = IS_LAST ? (en && ce) : en;
    end

    always_ff @(posedge clk) begin
        if (rst_latch)     latch <= RST_VAL;
        else if (ld_latch) latch <= rd_word;
    end

    generate
        if (IS_LAST) begin : g_last
            p_latch_rst_r9: assert property (@(posedge clk) disable iff (!past_ok)
                rst |=> latch == RST_VAL);
            p_latch_hold_r9: assert property (@(posedge clk) disable iff (!past_ok)
                (!rst && !(en && ce)) |=> $stable(latch));
        end else begin : g_mid
            p_write_first_r2: assert property (@(posedge clk) disable iff (!past_ok)
                (en && we) |=> latch == $past(wdata));
            p_latch_hold_r4: assert property (@(posedge clk) disable iff (!past_ok)
                !en |=> $stable(latch));
        end
    endgenerate
endmodule

// File: rtl/rdp_stage.sv
`timescale 1ns/1ps
module rdp_stage #(
    parameter int                DATA_W  = 16,
    parameter bit                IS_LAST = 1'b0,
    parameter logic [DATA_W-1:0] RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    logic do_rst;
    logic do_load;
    logic past_ok = 1'b0;

    always_ff @(posedge clk) past_ok <= 1'b1;

    always_comb begin
        do_rst  = IS_LAST && rst;
        do_load = IS_LAST ? ce : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_rst)       q <= RST_VAL;
        else if (do_load) q <= d;
    end

    generate
        if (IS_LAST) begin : g_last
            p_rst_load_r5: assert property (@(posedge clk) disable iff (!past_ok)
                rst |=> q == RST_VAL);
            p_rst_over_ce_r6: assert property (@(posedge clk) disable iff (!past_ok)
                (rst && ce) |=> q == RST_VAL);
            p_hold_r7: assert property (@(posedge clk) disable iff (!past_ok)
                (!rst && !ce) |=> $stable(q));
        end else begin : g_mid
            p_advance_r8: assert property (@(posedge clk) disable iff (!past_ok)
                (rst || !ce) |=> q == $past(d));
        end
    endgenerate
endmodule

// File: rtl/rdp_ram_top.sv
`timescale 1ns/1ps
module rdp_ram_top #(
    parameter int                DATA_W       = 16,
    parameter int                DEPTH        = 16,
    parameter bit                USE_PRIM_REG = 1'b1,
    parameter int                PIPE_REGS    = 2,
    parameter bit                USE_CORE_REG = 1'b1,
    parameter logic [DATA_W-1:0] RST_VAL      = 16'hFFFF,
    localparam int               ADDR_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              out_rst,
    input  logic              out_ce,
    output logic [DATA_W-1:0] rdata
);
    import rdp_pkg::*;

    localparam int NSTG = stage_count(USE_PRIM_REG, PIPE_REGS, USE_CORE_REG);

    // chain[0] is the latch, chain[NSTG] drives the port
    logic [DATA_W-1:0] chain [NSTG+1];

    rdp_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .IS_LAST(NSTG == 0),
        .RST_VAL(RST_VAL)
    ) u_array (
        .clk  (clk),
        .en   (en),
        .we   (we),
        .addr (addr),
        .wdata(wdata),
        .rst  (out_rst),
        .ce   (out_ce),
        .latch(chain[0])
    );

    generate
        for (genvar i = 0; i < NSTG; i++) begin : g_stage
            rdp_stage #(
                .DATA_W (DATA_W),
                .IS_LAST(i == NSTG - 1),
                .RST_VAL(RST_VAL)
            ) u_stage (
                .clk(clk),
                .rst(out_rst),
                .ce (out_ce),
                .d  (chain[i]),
                .q  (chain[i+1])
            );
        end
    endgenerate

    assign rdata = chain[NSTG];
endmodule

// File: tb/test_rdp_ram_top.sv
`timescale 1ns/1ps
module test_rdp_ram_top;
    localparam int DW = 16;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam logic [DW-1:0] RV = 16'hFFFF;
    localparam int LAT_A = 5; // 1 + 1 + 2 + 1

    logic clk = 1'b0;
    logic en = 1'b0, we = 1'b0, out_rst = 1'b0, out_ce = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_a, rd_b;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rdp_ram_top #(.DATA_W(DW), .DEPTH(DEPTH), .RST_VAL(RV)) i_rdp_ram_top (
        .clk(clk), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .out_rst(out_rst), .out_ce(out_ce), .rdata(rd_a));

    rdp_ram_top #(.DATA_W(DW), .DEPTH(DEPTH), .USE_PRIM_REG(1'b0), .PIPE_REGS(0),
                  .USE_CORE_REG(1'b0), .RST_VAL(RV)) i_latch_only (
        .clk(clk), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .out_rst(out_rst), .out_ce(out_ce), .rdata(rd_b));

    function automatic logic [DW-1:0] dat(input int a);
        return DW'((a * 16'h00F1) ^ 16'hA5A5);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] prev;
        @(negedge clk);
        // R1: fill array
        for (int a = 0; a < DEPTH; a++) begin
            en = 1; we = 1; addr = AW'(a); wdata = dat(a);
            tick();
        end
        en = 0; we = 0;
        for (int k = 0; k < 6; k++) tick();
        prev = dat(DEPTH - 1);
        check("R2 write-first latch-only", rd_b, prev);
        check("R2 write-first pipelined", rd_a, prev);

        // R3/R4/R1 sweep of reads
        for (int a = 0; a < DEPTH; a++) begin
            en = 1; addr = AW'(a);
            tick();
            en = 0;
            check("R3 latency 1 latch-only", rd_b, dat(a));
            for (int k = 1; k < LAT_A - 1; k++) tick();
            check("R3 no early change", rd_a, prev);
            tick();
            check("R3 latency 5 pipelined", rd_a, dat(a));
            check("R4 latch holds with en low", rd_b, dat(a));
            prev = dat(a);
        end
        for (int k = 0; k < 2; k++) tick();

        // R5: reset with en low
        out_rst = 1; tick(); out_rst = 0;
        check("R5 reset pipelined", rd_a, RV);
        check("R5 R9 reset latch-only", rd_b, RV);
        tick();
        check("R8 earlier stages not reset", rd_a, dat(DEPTH - 1));
        check("R9 latch-only stays reset with en low", rd_b, RV);

        // R7/R8/R9: clock enable low
        out_ce = 0; en = 1; addr = 3; tick(); en = 0;
        check("R9 ce low blocks latch", rd_b, RV);
        for (int k = 0; k < 6; k++) tick();
        check("R7 last stage holds", rd_a, dat(DEPTH - 1));
        out_ce = 1; tick();
        check("R8 upstream advanced while held", rd_a, dat(3));
        en = 1; tick(); en = 0;
        check("R9 latch-only reads with ce high", rd_b, dat(3));

        // R6: reset beats clock enable
        out_rst = 1; en = 1; addr = 4; tick(); out_rst = 0; en = 0;
        check("R6 reset over ce pipelined", rd_a, RV);
        check("R6 reset over ce latch-only", rd_b, RV);
        for (int k = 0; k < 6; k++) tick();

        // R2: write-first through the full pipeline
        en = 1; we = 1; addr = 5; wdata = 16'hBEEF; tick(); en = 0; we = 0;
        check("R2 write-first latch-only", rd_b, 16'hBEEF);
        for (int k = 1; k < LAT_A; k++) tick();
        check("R2 write-first pipelined", rd_a, 16'hBEEF);

        // R1: write with en low is ignored
        we = 1; addr = 6; wdata = 16'h1234; tick(); we = 0;
        check("R4 latch-only unchanged by en-low write", rd_b, 16'hBEEF);
        en = 1; tick(); en = 0;
        check("R1 en-low write ignored latch-only", rd_b, dat(6));
        for (int k = 1; k < LAT_A; k++) tick();
        check("R1 en-low write ignored pipelined", rd_a, dat(6));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule